// File: doc/BRIEF.md
# Event Record Log With Handle-Checked Removal

This block keeps several independent logs of fixed-size event records. Each log holds up to eight records in arrival order. When a record is accepted, the block stamps it with a nonzero 16-bit handle and with the value of the free-running time input. If a record arrives while its log is full, it is discarded. The log then counts the loss and keeps the time of the first and the most recent loss.

A host reaches the logs through a command port that handles one command at a time. A read command streams up to N records from the head of one log, one per cycle, and leaves them in place. The response carries a flag for a nonempty log and, when losses have occurred, the loss count and both loss times. A clear command carries a list of handles. The block compares the list against the log from the head. If every compared handle matches, it removes that many records. If any handle is zero or differs, it removes nothing and returns an error code. Each log drives a status bit and a one-cycle interrupt request that fires when the log goes from empty to occupied.

Top module: `event_record_log`

## Requirements
- R1: After reset every status bit and interrupt request is low, `busy` and `done` are low and `ins_ready` is high.
- R2: A log holds at most DEPTH (8) records. An insert into a full log stores nothing and is counted as an overflow.
- R3: On each overflow the overflow count rises by one and the last-overflow time takes `now_ts`. The first-overflow time takes `now_ts` only when the count was zero before that overflow.
- R4: The first accepted record of each log after reset gets handle 1. Each later accepted record gets the previous handle plus one, and a value that wraps to 0 is replaced by 1, so handle 0 is never issued.
- R5: A stored record carries the handle from R4, the `now_ts` value of its insert cycle and the `ins_data` supplied with it.
- R6: `irq_req[i]` is high for exactly the one cycle after an accepted insert that found log i empty, and is never high otherwise.
- R7: `log_status[i]` is high in the cycle after an accepted insert into log i. It falls in the `done` cycle of a clear that empties log i.
- R8: A read (`cmd_op`=0) streams min(`cmd_num`, held count) records from the head, oldest first, with `rec_idx` counting from 0. It reports that number in `rsp_nrec` and removes nothing.
- R9: A read response sets `rsp_more` when the log is nonempty. When the overflow count is nonzero, it sets `rsp_ovf` and reports the count and both overflow times.
- R10: A clear (`cmd_op`=1) compares handle slot k, at `cmd_handles[k*HDL_W +: HDL_W]`, with the k-th record from the head, for k below min(`cmd_num`, held count). If any compared slot is zero or differs, it returns `rsp_code`=1, reports `rsp_nrec`=0 and removes nothing.
- R11: A clear whose compared slots all match returns `rsp_code`=0 and removes min(`cmd_num`, held count) head records, reported in `rsp_nrec`. Any removal of one or more records sets the overflow count and both overflow times to zero.
- R12: A log selector of NUM_LOGS or above makes a read or clear return `rsp_code`=1 with `rsp_nrec`=0, and makes an insert change no log.
- R13: A command is accepted in an idle cycle with `cmd_valid` high. `busy` is high from the next cycle through a one-cycle `done`. `ins_ready` is low while `busy` or `cmd_valid` is high. The response fields are valid in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert may be taken this cycle |
| ins_log | input | SEL_W | Target log of the insert |
| ins_data | input | 32 | Record payload |
| now_ts | input | 32 | Current time, stamped on records and overflows |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 1 | 0 read, 1 clear |
| cmd_log | input | SEL_W | Log addressed by the command |
| cmd_num | input | CNT_W | Maximum record count (read) or handle count (clear) |
| cmd_handles | input | DEPTH*HDL_W | Handle list for clear, slot k at bits k*HDL_W |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_code | output | 1 | 0 success, 1 invalid input |
| rsp_nrec | output | CNT_W | Records returned or removed |
| rsp_more | output | 1 | Log was nonempty at a read |
| rsp_ovf | output | 1 | Overflow count was nonzero at a read |
| rsp_ovf_cnt | output | 16 | Overflow count |
| rsp_ovf_first | output | 32 | Time of first overflow |
| rsp_ovf_last | output | 32 | Time of latest overflow |
| rec_valid | output | 1 | Streamed record valid |
| rec_idx | output | CNT_W | Position of the streamed record from the head |
| rec_handle | output | HDL_W | Handle of the streamed record |
| rec_ts | output | 32 | Time stamp of the streamed record |
| rec_data | output | 32 | Payload of the streamed record |
| log_status | output | NUM_LOGS | Per-log nonempty status |
| irq_req | output | NUM_LOGS | Per-log interrupt request pulse |

## Verification
A wrong head pointer or occupancy count appears at the ports at the next read. The streamed handles or time stamps come out in the wrong order, or `rsp_nrec` differs from the expected minimum. A wrong count can also show up one cycle after an insert, as a missing or extra `irq_req` pulse. A handle counter that does not skip zero is seen at the first read after the wrap. A clear that removes records on a mismatch is seen at the following read, through a changed record count and overflow fields that were lost. An overflow register that is not reset on removal is reported at the next read through `rsp_ovf`.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

    localparam int EV_DATA_W = 32;
    localparam int EV_TS_W   = 32;
    localparam int EV_OVF_W  = 16;

    typedef logic [EV_DATA_W-1:0] ev_data_t;
    typedef logic [EV_TS_W-1:0]   ev_ts_t;

    // Loss bookkeeping of one log.
    typedef struct packed {
        logic [EV_OVF_W-1:0] cnt;
        ev_ts_t              first;
        ev_ts_t              last;
    } ovf_info_t;

    typedef enum logic {
        OP_GET   = 1'b0,
        OP_CLEAR = 1'b1
    } cmd_op_e;

    typedef enum logic {
        RC_OK      = 1'b0,
        RC_INVALID = 1'b1
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GET,
        ST_CLR,
        ST_DONE
    } cmd_state_e;

    // Loss counter saturates instead of wrapping.
    function automatic logic [EV_OVF_W-1:0] ovf_bump(input logic [EV_OVF_W-1:0] c);
        return (&c) ? c : c + 1'b1;
    endfunction

endpackage

// File: rtl/evlog_queue.sv
module evlog_queue
    import evlog_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int HDL_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  ev_data_t         push_data,
    input  ev_ts_t           push_ts,
    input  logic [CNT_W-1:0] pop_n,
    output logic [CNT_W-1:0] count,
    output ovf_info_t        ovf,
    output logic [HDL_W-1:0] ord_hdl  [DEPTH],
    output ev_ts_t           ord_ts   [DEPTH],
    output ev_data_t         ord_data [DEPTH],
    output logic             status,
    output logic             irq
);

    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;
    logic [HDL_W-1:0] next_hdl;
    logic             full;
    logic             accept;

    logic [HDL_W-1:0] mem_hdl  [DEPTH];
    ev_ts_t           mem_ts   [DEPTH];
    ev_data_t         mem_data [DEPTH];

    function automatic logic [HDL_W-1:0] adv_handle(input logic [HDL_W-1:0] h);
        logic [HDL_W-1:0] n;
        n = h + 1'b1;
        return (n == '0) ? {{(HDL_W-1){1'b0}}, 1'b1} : n;
    endfunction

    assign full   = (count == CNT_W'(DEPTH));
    assign accept = push && !full;
    assign tail   = head + count[PTR_W-1:0];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem_hdl[tail]  <= next_hdl;
            mem_ts[tail]   <= push_ts;
            mem_data[tail] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head     <= '0;
            count    <= '0;
            next_hdl <= {{(HDL_W-1){1'b0}}, 1'b1};
            ovf      <= '0;
            status   <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq   <= accept && (count == '0);
            count <= count + CNT_W'(accept) - pop_n;
            if (accept) begin
                next_hdl <= adv_handle(next_hdl);
                status   <= 1'b1;
            end else if (pop_n != '0 && pop_n == count) begin
                status <= 1'b0;
            end
            if (push && full) begin
                if (ovf.cnt == '0) begin
                    ovf.first <= push_ts;
                end
                ovf.last <= push_ts;
                ovf.cnt  <= ovf_bump(ovf.cnt);
            end
            if (pop_n != '0) begin
                head <= head + pop_n[PTR_W-1:0];
                ovf  <= '0;
            end
        end
    end

    // Present the contents in head order.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ord
        assign ord_hdl[g]  = mem_hdl[head + PTR_W'(g)];
        assign ord_ts[g]   = mem_ts[head + PTR_W'(g)];
        assign ord_data[g] = mem_data[head + PTR_W'(g)];
    end

endmodule

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
    import evlog_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HDL_W    = 16,
    parameter int NUM_LOGS = 4,
    parameter int SEL_W    = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic                   cmd_op,
    input  logic [SEL_W-1:0]       cmd_log,
    input  logic [CNT_W-1:0]       cmd_num,
    input  logic [DEPTH*HDL_W-1:0] cmd_handles,
    input  logic [CNT_W-1:0]       v_count,
    input  ovf_info_t              v_ovf,
    input  logic [HDL_W-1:0]       v_hdl  [DEPTH],
    input  ev_ts_t                 v_ts   [DEPTH],
    input  ev_data_t               v_data [DEPTH],
    output logic [SEL_W-1:0]       view_log,
    output logic [CNT_W-1:0]       pop_n,
    output logic                   busy,
    output logic                   done,
    output logic                   ins_ready,
    output logic                   rsp_code,
    output logic [CNT_W-1:0]       rsp_nrec,
    output logic                   rsp_more,
    output logic                   rsp_ovf,
    output ovf_info_t              rsp_ovf_info,
    output logic                   rec_valid,
    output logic [CNT_W-1:0]       rec_idx,
    output logic [HDL_W-1:0]       rec_handle,
    output ev_ts_t                 rec_ts,
    output ev_data_t               rec_data
);

    cmd_state_e             state;
    logic [SEL_W-1:0]       lat_log;
    logic [CNT_W-1:0]       lat_n;
    logic [DEPTH*HDL_W-1:0] lat_handles;
    logic [CNT_W-1:0]       idx;
    logic [CNT_W-1:0]       clr_m;
    logic [DEPTH-1:0]       slot_bad;
    logic                   clr_bad;
    logic                   log_ok;
    logic [PTR_W-1:0]       rd_slot;

    function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    assign log_ok   = (int'(cmd_log) < NUM_LOGS);
    assign view_log = (state == ST_IDLE) ? cmd_log : lat_log;
    assign clr_m    = clamp(lat_n, v_count);

    // One comparator per handle slot; slots past the compared range never fail.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [HDL_W-1:0] want;
        assign want        = lat_handles[g*HDL_W +: HDL_W];
        assign slot_bad[g] = (CNT_W'(g) < clr_m) && ((want == '0) || (want != v_hdl[g]));
    end
    assign clr_bad = |slot_bad;

    assign pop_n     = (state == ST_CLR && !clr_bad) ? clr_m : '0;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign ins_ready = (state == ST_IDLE) && !cmd_valid;

    assign rd_slot    = idx[PTR_W-1:0];
    assign rec_valid  = (state == ST_GET) && (idx != lat_n);
    assign rec_idx    = idx;
    assign rec_handle = v_hdl[rd_slot];
    assign rec_ts     = v_ts[rd_slot];
    assign rec_data   = v_data[rd_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            lat_log      <= '0;
            lat_n        <= '0;
            lat_handles  <= '0;
            idx          <= '0;
            rsp_code     <= RC_OK;
            rsp_nrec     <= '0;
            rsp_more     <= 1'b0;
            rsp_ovf      <= 1'b0;
            rsp_ovf_info <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        lat_log      <= cmd_log;
                        lat_handles  <= cmd_handles;
                        idx          <= '0;
                        rsp_more     <= 1'b0;
                        rsp_ovf      <= 1'b0;
                        rsp_ovf_info <= '0;
                        rsp_nrec     <= '0;
                        if (!log_ok) begin
                            rsp_code <= RC_INVALID;
                            state    <= ST_DONE;
                        end else if (cmd_op == OP_GET) begin
                            lat_n        <= clamp(cmd_num, v_count);
                            rsp_code     <= RC_OK;
                            rsp_nrec     <= clamp(cmd_num, v_count);
                            rsp_more     <= (v_count != '0);
                            rsp_ovf      <= (v_ovf.cnt != '0);
                            rsp_ovf_info <= v_ovf;
                            state        <= ST_GET;
                        end else begin
                            lat_n <= cmd_num;
                            state <= ST_CLR;
                        end
                    end
                end
                ST_GET: begin
                    if (idx == lat_n) begin
                        state <= ST_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_CLR: begin
                    rsp_code <= clr_bad ? RC_INVALID : RC_OK;
                    rsp_nrec <= clr_bad ? '0 : clr_m;
                    state    <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/event_record_log.sv
module event_record_log
    import evlog_pkg::*;
#(
    parameter int NUM_LOGS = 4,
    parameter int SEL_W    = 3,
    parameter int DEPTH    = 8,
    parameter int HDL_W    = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins_valid,
    output logic                   ins_ready,
    input  logic [SEL_W-1:0]       ins_log,
    input  logic [EV_DATA_W-1:0]   ins_data,
    input  logic [EV_TS_W-1:0]     now_ts,
    input  logic                   cmd_valid,
    input  logic                   cmd_op,
    input  logic [SEL_W-1:0]       cmd_log,
    input  logic [CNT_W-1:0]       cmd_num,
    input  logic [DEPTH*HDL_W-1:0] cmd_handles,
    output logic                   busy,
    output logic                   done,
    output logic                   rsp_code,
    output logic [CNT_W-1:0]       rsp_nrec,
    output logic                   rsp_more,
    output logic                   rsp_ovf,
    output logic [EV_OVF_W-1:0]    rsp_ovf_cnt,
    output logic [EV_TS_W-1:0]     rsp_ovf_first,
    output logic [EV_TS_W-1:0]     rsp_ovf_last,
    output logic                   rec_valid,
    output logic [CNT_W-1:0]       rec_idx,
    output logic [HDL_W-1:0]       rec_handle,
    output logic [EV_TS_W-1:0]     rec_ts,
    output logic [EV_DATA_W-1:0]   rec_data,
    output logic [NUM_LOGS-1:0]    log_status,
    output logic [NUM_LOGS-1:0]    irq_req
);

    logic [CNT_W-1:0] q_count [NUM_LOGS];
    ovf_info_t        q_ovf   [NUM_LOGS];
    logic [HDL_W-1:0] q_hdl   [NUM_LOGS][DEPTH];
    ev_ts_t           q_ts    [NUM_LOGS][DEPTH];
    ev_data_t         q_data  [NUM_LOGS][DEPTH];

    logic [SEL_W-1:0] view_log;
    logic [CNT_W-1:0] pop_n;
    logic [CNT_W-1:0] v_count;
    ovf_info_t        v_ovf;
    logic [HDL_W-1:0] v_hdl  [DEPTH];
    ev_ts_t           v_ts   [DEPTH];
    ev_data_t         v_data [DEPTH];
    ovf_info_t        rsp_ovf_info;

    for (genvar l = 0; l < NUM_LOGS; l++) begin : g_log
        logic             push_l;
        logic [CNT_W-1:0] pop_l;
        assign push_l = ins_valid && ins_ready && (int'(ins_log) == l);
        assign pop_l  = (int'(view_log) == l) ? pop_n : '0;

        evlog_queue #(
            .DEPTH (DEPTH),
            .HDL_W (HDL_W)
        ) u_queue (
            .clk       (clk),
            .rst       (rst),
            .push      (push_l),
            .push_data (ins_data),
            .push_ts   (now_ts),
            .pop_n     (pop_l),
            .count     (q_count[l]),
            .ovf       (q_ovf[l]),
            .ord_hdl   (q_hdl[l]),
            .ord_ts    (q_ts[l]),
            .ord_data  (q_data[l]),
            .status    (log_status[l]),
            .irq       (irq_req[l])
        );
    end

    // Present the addressed log to the command engine; out-of-range reads as empty.
    always_comb begin
        v_count = '0;
        v_ovf   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            v_hdl[k]  = '0;
            v_ts[k]   = '0;
            v_data[k] = '0;
        end
        for (int l = 0; l < NUM_LOGS; l++) begin
            if (int'(view_log) == l) begin
                v_count = q_count[l];
                v_ovf   = q_ovf[l];
                for (int k = 0; k < DEPTH; k++) begin
                    v_hdl[k]  = q_hdl[l][k];
                    v_ts[k]   = q_ts[l][k];
                    v_data[k] = q_data[l][k];
                end
            end
        end
    end

    evlog_ctrl #(
        .DEPTH    (DEPTH),
        .HDL_W    (HDL_W),
        .NUM_LOGS (NUM_LOGS),
        .SEL_W    (SEL_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_log      (cmd_log),
        .cmd_num      (cmd_num),
        .cmd_handles  (cmd_handles),
        .v_count      (v_count),
        .v_ovf        (v_ovf),
        .v_hdl        (v_hdl),
        .v_ts         (v_ts),
        .v_data       (v_data),
        .view_log     (view_log),
        .pop_n        (pop_n),
        .busy         (busy),
        .done         (done),
        .ins_ready    (ins_ready),
        .rsp_code     (rsp_code),
        .rsp_nrec     (rsp_nrec),
        .rsp_more     (rsp_more),
        .rsp_ovf      (rsp_ovf),
        .rsp_ovf_info (rsp_ovf_info),
        .rec_valid    (rec_valid),
        .rec_idx      (rec_idx),
        .rec_handle   (rec_handle),
        .rec_ts       (rec_ts),
        .rec_data     (rec_data)
    );

    assign rsp_ovf_cnt   = rsp_ovf_info.cnt;
    assign rsp_ovf_first = rsp_ovf_info.first;
    assign rsp_ovf_last  = rsp_ovf_info.last;

endmodule

// File: rtl/event_record_log_chk.sv
module event_record_log_chk #(
    parameter int NUM_LOGS = 4,
    parameter int DEPTH    = 8,
    parameter int HDL_W    = 16,
    parameter int CNT_W    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                ins_ready,
    input logic                busy,
    input logic                done,
    input logic                rsp_code,
    input logic [CNT_W-1:0]    rsp_nrec,
    input logic                rsp_ovf,
    input logic [15:0]         rsp_ovf_cnt,
    input logic                rec_valid,
    input logic [CNT_W-1:0]    rec_idx,
    input logic [HDL_W-1:0]    rec_handle,
    input logic [NUM_LOGS-1:0] log_status,
    input logic [NUM_LOGS-1:0] irq_req
);

    // R4
    nonzero_handle_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_handle != '0));

    // R8
    stream_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (int'(rec_idx) < DEPTH));

    // R8
    stream_in_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> busy);

    // R13
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ins_ready);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    invalid_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_code) |-> (rsp_nrec == '0));

    // R9
    ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_ovf) |-> (rsp_ovf_cnt != '0));

    for (genvar l = 0; l < NUM_LOGS; l++) begin : g_per_log
        // R6
        irq_status_chk: assert property (@(posedge clk) disable iff (rst)
            irq_req[l] |-> log_status[l]);

        // R6
        irq_single_chk: assert property (@(posedge clk) disable iff (rst)
            irq_req[l] |=> !irq_req[l]);

        // R7
        status_fall_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(log_status[l]) |-> done);
    end

endmodule

bind event_record_log event_record_log_chk #(
    .NUM_LOGS (NUM_LOGS),
    .DEPTH    (DEPTH),
    .HDL_W    (HDL_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ins_ready   (ins_ready),
    .busy        (busy),
    .done        (done),
    .rsp_code    (rsp_code),
    .rsp_nrec    (rsp_nrec),
    .rsp_ovf     (rsp_ovf),
    .rsp_ovf_cnt (rsp_ovf_cnt),
    .rec_valid   (rec_valid),
    .rec_idx     (rec_idx),
    .rec_handle  (rec_handle),
    .log_status  (log_status),
    .irq_req     (irq_req)
);

// File: tb/event_record_log_bench.sv
`timescale 1ns/1ps
module event_record_log_bench;

    localparam int NL = 3;
    localparam int SW = 2;
    localparam int DP = 8;
    localparam int HW = 4;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic            ins_valid, ins_ready;
    logic [SW-1:0]   ins_log;
    logic [31:0]     ins_data, now_ts;
    logic            cmd_valid, cmd_op;
    logic [SW-1:0]   cmd_log;
    logic [CW-1:0]   cmd_num;
    logic [DP*HW-1:0] cmd_handles;
    logic            busy, done, rsp_code, rsp_more, rsp_ovf;
    logic [CW-1:0]   rsp_nrec, rec_idx;
    logic [15:0]     rsp_ovf_cnt;
    logic [31:0]     rsp_ovf_first, rsp_ovf_last, rec_ts, rec_data;
    logic            rec_valid;
    logic [HW-1:0]   rec_handle;
    logic [NL-1:0]   log_status, irq_req;

    event_record_log #(.NUM_LOGS(NL), .SEL_W(SW), .DEPTH(DP), .HDL_W(HW)) u_event_record_log (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_log(ins_log),
        .ins_data(ins_data), .now_ts(now_ts), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_log(cmd_log), .cmd_num(cmd_num), .cmd_handles(cmd_handles), .busy(busy), .done(done),
        .rsp_code(rsp_code), .rsp_nrec(rsp_nrec), .rsp_more(rsp_more), .rsp_ovf(rsp_ovf),
        .rsp_ovf_cnt(rsp_ovf_cnt), .rsp_ovf_first(rsp_ovf_first), .rsp_ovf_last(rsp_ovf_last),
        .rec_valid(rec_valid), .rec_idx(rec_idx), .rec_handle(rec_handle), .rec_ts(rec_ts),
        .rec_data(rec_data), .log_status(log_status), .irq_req(irq_req)
    );

    int nchk = 0;
    int nfail = 0;

    // Reference model, head at index 0.
    int          m_cnt  [NL];
    int          m_next [NL];
    int          m_ovf  [NL];
    logic [31:0] m_first[NL];
    logic [31:0] m_last [NL];
    int          m_hdl  [NL][DP];
    logic [31:0] m_ts   [NL][DP];
    logic [31:0] m_dat  [NL][DP];

    int          g_n;
    int          g_hdl [16];
    logic [31:0] g_ts  [16];
    logic [31:0] g_dat [16];
    int unsigned seed = 32'h1234_5678;

    task automatic chk(string req, string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned rnd(int unsigned m);
        seed = seed * 32'd1103515245 + 32'd12345;
        return (seed >> 16) % m;
    endfunction

    function automatic logic [NL-1:0] exp_status();
        logic [NL-1:0] s;
        for (int l = 0; l < NL; l++) s[l] = (m_cnt[l] != 0);
        return s;
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic do_insert(int lg, logic [31:0] d, logic [31:0] t);
        logic [NL-1:0] exp_irq;
        exp_irq = '0;
        @(negedge clk);
        chk("R13", "ins_ready idle", ins_ready, 1);
        ins_valid = 1'b1; ins_log = SW'(lg); ins_data = d; now_ts = t;
        @(negedge clk);
        ins_valid = 1'b0;
        if (lg < NL) begin
            if (m_cnt[lg] < DP) begin
                m_hdl[lg][m_cnt[lg]] = m_next[lg];
                m_ts[lg][m_cnt[lg]]  = t;
                m_dat[lg][m_cnt[lg]] = d;
                if (m_cnt[lg] == 0) exp_irq[lg] = 1'b1;
                m_cnt[lg]++;
                m_next[lg] = (m_next[lg] + 1) % (1 << HW);
                if (m_next[lg] == 0) m_next[lg] = 1;
            end else begin
                if (m_ovf[lg] == 0) m_first[lg] = t;
                m_last[lg] = t;
                m_ovf[lg]++;
            end
        end
        chk("R6", "irq after insert", irq_req, exp_irq);
        chk("R7/R12", "status after insert", log_status, exp_status());
        @(negedge clk);
        chk("R6", "irq one cycle", irq_req, 0);
    endtask

    task automatic do_cmd(logic op, int lg, int num, logic [DP*HW-1:0] hl);
        int guard;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_log = SW'(lg); cmd_num = CW'(num); cmd_handles = hl;
        #1;
        chk("R13", "ins_ready with cmd_valid", ins_ready, 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        g_n = 0;
        guard = 0;
        while (!done && guard < 40) begin
            if (rec_valid) begin
                chk("R8", "rec_idx", rec_idx, g_n);
                g_hdl[g_n] = rec_handle; g_ts[g_n] = rec_ts; g_dat[g_n] = rec_data;
                g_n++;
            end
            chk("R13", "busy/ready during cmd", {busy, ins_ready}, 2'b10);
            @(negedge clk);
            guard++;
        end
        chk("R13", "done reached", done, 1);
    endtask

    task automatic finish_cmd();
        @(negedge clk);
        chk("R13", "done pulse ends", {done, busy}, 0);
    endtask

    task automatic do_get(int lg, int num);
        int n;
        do_cmd(1'b0, lg, num, '0);
        if (lg >= NL) begin
            chk("R12", "get bad log code", rsp_code, 1);
            chk("R12", "get bad log nrec", rsp_nrec, 0);
        end else begin
            n = imin(num, m_cnt[lg]);
            chk("R8", "get code", rsp_code, 0);
            chk("R8", "get nrec", rsp_nrec, n);
            chk("R8", "streamed count", g_n, n);
            for (int i = 0; i < n && i < g_n; i++) begin
                chk("R4", "handle", g_hdl[i], m_hdl[lg][i]);
                chk("R5", "time stamp", g_ts[i], m_ts[lg][i]);
                chk("R5", "payload", g_dat[i], m_dat[lg][i]);
            end
            chk("R9", "more flag", rsp_more, m_cnt[lg] != 0);
            chk("R9", "ovf flag", rsp_ovf, m_ovf[lg] != 0);
            if (m_ovf[lg] != 0) begin
                chk("R3", "ovf count", rsp_ovf_cnt, m_ovf[lg]);
                chk("R3", "ovf first", rsp_ovf_first, m_first[lg]);
                chk("R3", "ovf last", rsp_ovf_last, m_last[lg]);
            end
        end
        finish_cmd();
    endtask

    // Build a handle list from the model; corrupt slot bad_at (-1 none), zero slot zero_at.
    function automatic logic [DP*HW-1:0] mk_list(int lg, int bad_at, int zero_at);
        logic [DP*HW-1:0] v;
        v = '0;
        if (lg < NL) begin
            for (int i = 0; i < m_cnt[lg]; i++) v[i*HW +: HW] = HW'(m_hdl[lg][i]);
        end
        if (bad_at >= 0) v[bad_at*HW +: HW] = v[bad_at*HW +: HW] + HW'(1) == '0 ? HW'(2) : v[bad_at*HW +: HW] + HW'(1);
        if (zero_at >= 0) v[zero_at*HW +: HW] = '0;
        return v;
    endfunction

    task automatic do_clear(int lg, int num, logic [DP*HW-1:0] hl);
        int m;
        bit bad;
        do_cmd(1'b1, lg, num, hl);
        if (lg >= NL) begin
            chk("R12", "clear bad log code", rsp_code, 1);
            chk("R12", "clear bad log nrec", rsp_nrec, 0);
        end else begin
            m = imin(num, m_cnt[lg]);
            bad = 0;
            for (int i = 0; i < m; i++) begin
                if (hl[i*HW +: HW] == '0 || int'(hl[i*HW +: HW]) != m_hdl[lg][i]) bad = 1;
            end
            if (bad) begin
                chk("R10", "clear reject code", rsp_code, 1);
                chk("R10", "clear reject nrec", rsp_nrec, 0);
            end else begin
                chk("R11", "clear code", rsp_code, 0);
                chk("R11", "clear nrec", rsp_nrec, m);
                for (int i = 0; i + m < m_cnt[lg]; i++) begin
                    m_hdl[lg][i] = m_hdl[lg][i+m];
                    m_ts[lg][i]  = m_ts[lg][i+m];
                    m_dat[lg][i] = m_dat[lg][i+m];
                end
                m_cnt[lg] -= m;
                if (m > 0) begin
                    m_ovf[lg] = 0; m_first[lg] = 0; m_last[lg] = 0;
                end
            end
        end
        chk("R7", "status at done", log_status, exp_status());
        finish_cmd();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) begin
            m_cnt[l] = 0; m_next[l] = 1; m_ovf[l] = 0; m_first[l] = 0; m_last[l] = 0;
        end
        rst = 1'b1; ins_valid = 0; ins_log = 0; ins_data = 0; now_ts = 0;
        cmd_valid = 0; cmd_op = 0; cmd_log = 0; cmd_num = 0; cmd_handles = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "status after reset", log_status, 0);
        chk("R1", "irq after reset", irq_req, 0);
        chk("R1", "busy/done after reset", {busy, done}, 0);
        chk("R1", "ins_ready after reset", ins_ready, 1);

        // Basic arrival order and partial reads on log 0.
        do_insert(0, 32'hA0, 32'd100);
        do_insert(0, 32'hA1, 32'd105);
        do_insert(0, 32'hA2, 32'd111);
        do_get(0, 2);
        do_get(0, 15);
        do_get(0, 0);
        do_get(1, 4);

        // Fill log 1 past its capacity: R2, R3.
        for (int i = 0; i < DP; i++) do_insert(1, 32'hB00 + i, 32'd200 + i);
        do_insert(1, 32'hDEAD, 32'd300);
        do_insert(1, 32'hDEAD, 32'd310);
        do_insert(1, 32'hDEAD, 32'd325);
        do_get(1, 15);

        // Rejected clears leave everything in place: R10.
        do_clear(1, 3, mk_list(1, 1, -1));
        do_get(1, 15);
        do_clear(1, 2, mk_list(1, -1, 0));
        do_get(1, 15);

        // Good clear removes head and resets overflow info: R11.
        do_clear(1, 2, mk_list(1, -1, -1));
        do_get(1, 15);
        // Count beyond held records, tail slots zero and ignored.
        do_clear(1, 15, mk_list(1, -1, -1));
        do_get(1, 4);
        do_clear(1, 3, '0);

        // Out-of-range selector: R12.
        do_insert(3, 32'h5555, 32'd400);
        do_get(3, 8);
        do_clear(3, 1, mk_list(0, -1, -1));
        do_get(0, 8);

        // Handle wrap on log 2: R4.
        for (int i = 0; i < 20; i++) begin
            do_insert(2, 32'hC00 + i, 32'd500 + i);
            do_get(2, 1);
            do_clear(2, 1, mk_list(2, -1, -1));
        end

        // Mixed sweep over all logs and selectors.
        for (int it = 0; it < 500; it++) begin
            int lg;
            int op;
            lg = int'(rnd(4));
            op = int'(rnd(10));
            if (op < 5) do_insert(lg, rnd(65536), 32'd1000 + it * 3);
            else if (op < 7) do_get(lg, int'(rnd(10)));
            else if (op < 8) do_clear(lg, int'(rnd(10)), mk_list(lg, int'(rnd(3)), -1));
            else do_clear(lg, int'(rnd(10)), mk_list(lg, -1, -1));
        end
        for (int l = 0; l < NL; l++) do_get(l, 15);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule